// File: doc/BRIEF.md
# Converter Read Sequencer

This block is the host side of a parallel link to a 12-bit sampling converter. It drives the converter's chip-select, read strobe and upper-byte enable, starts conversions, and collects the results. One request pulse produces one 12-bit result. The result is zero-extended to 16 bits and comes with a one-cycle valid pulse.

Two inputs set how each access runs. The timing input picks one of two modes. In the waiting mode, the read that starts a conversion stays active until the converter's busy line has gone low and come back high. In the non-waiting mode, every conversion-starting read returns the result of the conversion before it. The width input picks a full 12-line transfer or a transfer of two bytes over the low 8 lines. That gives four read sequences. In the longest one, used in non-waiting two-byte mode, the first read returns stale data and is thrown away. The second read fetches the top four bits, and the third fetches the low byte and starts the next conversion. The block keeps track of whether the converter already holds an unread result, so that non-waiting requests skip the throw-away read when they can.

All timing is set by parameters given in clock cycles: strobe width, conversion time, the minimum gap between conversions, and the busy timeout.

Top module: `cvrd_host`

## Requirements
- R1: After reset, chip-select and read are high (inactive), the upper-byte enable is low, and neither the result valid nor the timeout pulse is raised.
- R2: Waiting mode, full width: a single read starts a conversion. It is held until busy_n_i has been seen low and then high. The result is bus_i[11:0] as sampled in that first busy-high cycle. The valid pulse appears in the same cycle the strobes return high.
- R3: Waiting mode, two bytes: the first read behaves as in R2 but keeps bus_i[7:0] as result bits 7..0. A second read with the upper-byte enable high, lasting STROBE_CYC cycles, supplies result bits 11..8. It starts no conversion.
- R4: Non-waiting mode, full width: each read lasts STROBE_CYC cycles, starts a conversion, and returns bus_i[11:0] from its last low cycle. If no unread conversion is pending (after reset, after any waiting-mode sequence or timeout), the first read's data is discarded and a second read supplies the result.
- R5: Non-waiting mode, two bytes: the sequence is an upper-byte read followed by a low-byte read, and the low-byte read starts the next conversion. If no unread conversion is pending, a discarded conversion-starting read comes first.
- R6: A read with the upper-byte enable low starts a conversion. Its falling strobe is at least CONV_CYC+GAP_CYC cycles after the previous one.
- R7: An upper-byte read never begins fewer than CONV_CYC cycles after the last conversion start.
- R8: In two-byte width, result bits 7..0 come from bus_i[7:0] and bits 11..8 from bus_i[3:0] of the upper-byte read. bus_i[11:8] on byte reads and bus_i[11:4] on upper-byte reads are ignored.
- R9: res_o[15:12] is zero whenever res_valid_o is high, and res_valid_o is never high in two consecutive cycles.
- R10: In waiting mode, if the read has been low for TIMEOUT_CYC cycles without completing, the strobes are released and timeout_o pulses for one cycle with no valid. The next non-waiting request then starts with a discarded read.
- R11: A request arriving while a sequence runs, including in the cycle a result is delivered, causes exactly one further sequence. Further requests made while one is already waiting merge into it.
- R12: The mode and width inputs are sampled when a sequence is launched. Changing them during the sequence does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse for one result |
| slow_mode_i | input | 1 | 1 = waiting mode, 0 = non-waiting mode |
| byte_bus_i | input | 1 | 1 = two-byte transfer on 8 lines, 0 = full width |
| busy_n_i | input | 1 | Converter busy, low while converting |
| bus_i | input | DATA_W (12) | Converter data lines |
| cs_n_o | output | 1 | Chip-select to converter, active low |
| rd_n_o | output | 1 | Read strobe to converter, active low |
| hben_o | output | 1 | Upper-byte enable to converter |
| res_o | output | OUT_W (16) | Zero-extended result |
| res_valid_o | output | 1 | One-cycle result valid |
| timeout_o | output | 1 | One-cycle busy timeout flag |

## Verification
Two things can happen in the same cycle: a result is delivered, and the request holder captures a new request while the sequencer is leaving its last state. The bench provokes this by raising the request in exactly the cycle where the valid pulse is seen. It then expects a second result, taken from the conversion started by the first sequence's read, after exactly one more conversion start. A separate test makes repeated requests during a long non-waiting sequence and expects them to merge into one extra result.

// File: rtl/cvrd_pkg.sv
package cvrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP_A,
        ST_RD_A,
        ST_GAP_B,
        ST_RD_B,
        ST_GAP_C,
        ST_RD_C
    } cvrd_state_e;

endpackage

// File: rtl/cvrd_req_hold.sv
module cvrd_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = req_i | (pend_q & ~take_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/cvrd_gap_timer.sv
module cvrd_gap_timer #(
    parameter int CONV_CYC  = 40,
    parameter int SPACE_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic conv_ok_o,
    output logic space_ok_o
);
    localparam int SW = $clog2(SPACE_CYC + 1);
    localparam logic [SW-1:0] SAT  = SW'(SPACE_CYC);
    localparam logic [SW-1:0] CONV = SW'(CONV_CYC);

    logic [SW-1:0] since_d, since_q;

    always_comb begin
        if (restart_i)          since_d = '0;
        else if (since_q == SAT) since_d = since_q;
        else                    since_d = since_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_q <= SAT;
        else        since_q <= since_d;
    end

    assign conv_ok_o  = (since_q >= CONV);
    assign space_ok_o = (since_q >= SAT);
endmodule

// File: rtl/cvrd_pack.sv
module cvrd_pack #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 16
) (
    input  logic              byte_mode_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [7:0]        lo_i,
    input  logic [DATA_W-9:0] hi_i,
    output logic [OUT_W-1:0]  res_o
);
    localparam int PAD = OUT_W - DATA_W;

    logic [DATA_W-1:0] core;

    always_comb begin
        core = byte_mode_i ? {hi_i, lo_i} : word_i;
    end

    generate
        if (PAD > 0) begin : g_pad
            assign res_o = {{PAD{1'b0}}, core};
        end else begin : g_nopad
            assign res_o = core[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cvrd_host.sv
module cvrd_host
    import cvrd_pkg::*;
#(
    parameter int STROBE_CYC  = 3,
    parameter int CONV_CYC    = 40,
    parameter int GAP_CYC     = 30,
    parameter int TIMEOUT_CYC = 200,
    parameter int DATA_W      = 12,
    parameter int OUT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              slow_mode_i,
    input  logic              byte_bus_i,
    input  logic              busy_n_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              hben_o,
    output logic [OUT_W-1:0]  res_o,
    output logic              res_valid_o,
    output logic              timeout_o
);
    localparam int SPACE_CYC = CONV_CYC + GAP_CYC;
    localparam int TMAX      = (TIMEOUT_CYC > STROBE_CYC) ? TIMEOUT_CYC : STROBE_CYC;
    localparam int CNT_W     = $clog2(TMAX + 1);
    localparam int LO_W      = 8;
    localparam int HI_W      = DATA_W - LO_W;
    localparam logic [CNT_W-1:0] STROBE_LAST  = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        cvrd_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic              seen_low;
        logic              slow;
        logic              bytem;
        logic              primed;
        logic [LO_W-1:0]   lo;
        logic [HI_W-1:0]   hi;
        logic [OUT_W-1:0]  res;
        logic              vld;
        logic              err;
    } ctl_t;

    ctl_t q, d;

    logic              pend, take, start_now, conv_ok, space_ok;
    logic [LO_W-1:0]   lo_sel;
    logic [HI_W-1:0]   hi_sel;
    logic [OUT_W-1:0]  packed_res;

    cvrd_req_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .take_i (take),
        .pend_o (pend)
    );

    cvrd_gap_timer #(
        .CONV_CYC  (CONV_CYC),
        .SPACE_CYC (SPACE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (start_now),
        .conv_ok_o  (conv_ok),
        .space_ok_o (space_ok)
    );

    always_comb begin
        lo_sel = (q.st == ST_RD_C) ? bus_i[LO_W-1:0] : q.lo;
        hi_sel = (q.st == ST_RD_B) ? bus_i[HI_W-1:0] : q.hi;
    end

    cvrd_pack #(
        .DATA_W (DATA_W),
        .OUT_W  (OUT_W)
    ) u_pack (
        .byte_mode_i (q.bytem),
        .word_i      (bus_i),
        .lo_i        (lo_sel),
        .hi_i        (hi_sel),
        .res_o       (packed_res)
    );

    always_comb begin
        d         = q;
        d.vld     = 1'b0;
        d.err     = 1'b0;
        take      = 1'b0;
        start_now = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.cnt      = '0;
                d.seen_low = 1'b0;
                if (pend) begin
                    take    = 1'b1;
                    d.slow  = slow_mode_i;
                    d.bytem = byte_bus_i;
                    if (!slow_mode_i && byte_bus_i && q.primed) d.st = ST_GAP_B;
                    else                                         d.st = ST_GAP_A;
                end
            end
            ST_GAP_A: begin
                if (space_ok) begin
                    d.st       = ST_RD_A;
                    d.cnt      = '0;
                    d.seen_low = 1'b0;
                    start_now  = 1'b1;
                end
            end
            ST_RD_A: begin
                d.cnt = q.cnt + 1'b1;
                if (q.slow) begin
                    if (!busy_n_i) d.seen_low = 1'b1;
                    if (q.seen_low && busy_n_i) begin
                        d.primed = 1'b0;
                        if (q.bytem) begin
                            d.lo = bus_i[LO_W-1:0];
                            d.st = ST_GAP_B;
                        end else begin
                            d.res = packed_res;
                            d.vld = 1'b1;
                            d.st  = ST_IDLE;
                        end
                    end else if (q.cnt == TIMEOUT_LAST) begin
                        d.primed = 1'b0;
                        d.err    = 1'b1;
                        d.st     = ST_IDLE;
                    end
                end else if (q.cnt == STROBE_LAST) begin
                    if (!q.primed) begin
                        d.primed = 1'b1;
                        d.st     = q.bytem ? ST_GAP_B : ST_GAP_A;
                    end else begin
                        d.res = packed_res;
                        d.vld = 1'b1;
                        d.st  = ST_IDLE;
                    end
                end
            end
            ST_GAP_B: begin
                if (conv_ok) begin
                    d.st  = ST_RD_B;
                    d.cnt = '0;
                end
            end
            ST_RD_B: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == STROBE_LAST) begin
                    if (q.slow) begin
                        d.res = packed_res;
                        d.vld = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        d.hi = bus_i[HI_W-1:0];
                        d.st = ST_GAP_C;
                    end
                end
            end
            ST_GAP_C: begin
                if (space_ok) begin
                    d.st      = ST_RD_C;
                    d.cnt     = '0;
                    start_now = 1'b1;
                end
            end
            ST_RD_C: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == STROBE_LAST) begin
                    d.primed = 1'b1;
                    d.res    = packed_res;
                    d.vld    = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic strobe;
    assign strobe      = (q.st == ST_RD_A) || (q.st == ST_RD_B) || (q.st == ST_RD_C);
    assign cs_n_o      = ~strobe;
    assign rd_n_o      = ~strobe;
    assign hben_o      = (q.st == ST_RD_B);
    assign res_o       = q.res;
    assign res_valid_o = q.vld;
    assign timeout_o   = q.err;
endmodule

// File: rtl/cvrd_host_chk.sv
module cvrd_host_chk #(
    parameter int CONV_CYC    = 40,
    parameter int SPACE_CYC   = 70,
    parameter int TIMEOUT_CYC = 200,
    parameter int DATA_W      = 12,
    parameter int OUT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_o,
    input logic             rd_n_o,
    input logic             hben_o,
    input logic [OUT_W-1:0] res_o,
    input logic             res_valid_o,
    input logic             timeout_o
);
    int   since_q;
    int   low_q;
    logic rd_prev_q;
    logic start_evt, upper_evt;

    assign start_evt = rd_prev_q & ~rd_n_o & ~hben_o;
    assign upper_evt = rd_prev_q & ~rd_n_o & hben_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q   <= SPACE_CYC;
            low_q     <= 0;
            rd_prev_q <= 1'b1;
        end else begin
            rd_prev_q <= rd_n_o;
            if (start_evt)               since_q <= 0;
            else if (since_q < SPACE_CYC) since_q <= since_q + 1;
            if (rd_n_o)                   low_q <= 0;
            else if (low_q < TIMEOUT_CYC) low_q <= low_q + 1;
        end
    end

    AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> since_q >= SPACE_CYC) else $error("start spacing"); // R6
    AST_UPPER_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        upper_evt |-> since_q >= CONV_CYC) else $error("upper read early"); // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o) else $error("valid too long"); // R9
    AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_o >> DATA_W) == '0) else $error("upper bits set"); // R9
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!res_valid_o && rd_n_o && cs_n_o)) else $error("timeout state"); // R10
    AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> low_q < TIMEOUT_CYC) else $error("strobe too long"); // R10
endmodule

bind cvrd_host cvrd_host_chk #(
    .CONV_CYC    (CONV_CYC),
    .SPACE_CYC   (CONV_CYC + GAP_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DATA_W      (DATA_W),
    .OUT_W       (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .rd_n_o      (rd_n_o),
    .hben_o      (hben_o),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .timeout_o   (timeout_o)
);

// File: tb/sim_cvrd_host.sv
module sim_cvrd_host;
    localparam int STROBE_CYC  = 3;
    localparam int CONV_CYC    = 40;
    localparam int GAP_CYC     = 30;
    localparam int TIMEOUT_CYC = 120;
    localparam int SPACE_CYC   = CONV_CYC + GAP_CYC;
    localparam int MODEL_CONV  = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        slow = 1'b0;
    logic        byt = 1'b0;
    logic        busy_n = 1'b1;
    logic [11:0] latch = 12'h000;
    logic [11:0] bus;
    logic        cs_n_o, rd_n_o, hben_o, res_valid_o, timeout_o;
    logic [15:0] res_o;

    int  nchk = 0;
    int  nerr = 0;
    int  cyc = 0;
    int  n_start = 0;
    int  last_start = -100000;
    int  conv_left = 0;
    int  cur_idx = 0;
    bit  prev_str = 1'b0;
    bit  prev_hb = 1'b0;
    bit  dead = 1'b0;
    bit  noise = 1'b0;
    bit  hb_seen = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [11:0] sample(input int k);
        return 12'((k * 667 + 309) & 4095);
    endfunction

    assign bus = hben_o ? {(noise ? 8'hC5 : {latch[11:8], 4'h0}), latch[11:8]}
                        : {(noise ? 4'h9 : latch[11:8]), latch[7:0]};

    cvrd_host #(
        .STROBE_CYC  (STROBE_CYC),
        .CONV_CYC    (CONV_CYC),
        .GAP_CYC     (GAP_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .slow_mode_i (slow),
        .byte_bus_i  (byt),
        .busy_n_i    (busy_n),
        .bus_i       (bus),
        .cs_n_o      (cs_n_o),
        .rd_n_o      (rd_n_o),
        .hben_o      (hben_o),
        .res_o       (res_o),
        .res_valid_o (res_valid_o),
        .timeout_o   (timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter model and timing monitor
    always @(posedge clk) begin
        bit str, hb;
        if (rst_n) begin
            cyc++;
            str = !cs_n_o && !rd_n_o && !hben_o;
            hb  = !cs_n_o && !rd_n_o && hben_o;
            if (str && !prev_str) begin
                chk(cyc - last_start >= SPACE_CYC, "R6 start spacing", cyc - last_start, SPACE_CYC);
                last_start = cyc;
                if (!dead && conv_left == 0) begin
                    n_start++;
                    cur_idx   = n_start;
                    conv_left = MODEL_CONV;
                    busy_n   <= 1'b0;
                end
            end else if (conv_left > 0) begin
                if (conv_left == 1) begin
                    latch  <= sample(cur_idx);
                    busy_n <= 1'b1;
                end
                conv_left--;
            end
            if (hb && !prev_hb) begin
                hb_seen = 1'b1;
                chk(cyc - last_start >= CONV_CYC, "R7 upper read delay", cyc - last_start, CONV_CYC);
            end
            prev_str = str;
            prev_hb  = hb;
        end
    end

    task automatic pulse_req;
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic get_result(output bit v, output bit e, output logic [15:0] dat, output bit rel);
        v = 0; e = 0; dat = '0; rel = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (res_valid_o) begin
                v = 1; dat = res_o; rel = cs_n_o & rd_n_o;
                return;
            end
            if (timeout_o) begin
                e = 1; rel = cs_n_o & rd_n_o;
                return;
            end
        end
    endtask

    task automatic run_seq(input bit s, input bit b, input bit nz, input int exp_delta, input string tag);
        bit v, e, rel;
        logic [15:0] dat;
        int n0;
        logic [11:0] expd;
        slow = s; byt = b; noise = nz;
        n0 = n_start;
        pulse_req();
        get_result(v, e, dat, rel);
        expd = s ? sample(n_start) : sample(n_start - 1);
        chk(v && !e, {tag, " valid seen"}, v, 1);
        chk(rel, {tag, " strobes released at valid"}, rel, 1);
        chk(n_start - n0 == exp_delta, {tag, " conversion starts"}, n_start - n0, exp_delta);
        chk(dat == {4'h0, expd}, {tag, " data"}, dat, {4'h0, expd});
        @(negedge clk);
        chk(!res_valid_o, "R9 valid one cycle", res_valid_o, 0);
        noise = 1'b0;
    endtask

    task automatic t_reset;
        chk(cs_n_o && rd_n_o, "R1 strobes idle", {cs_n_o, rd_n_o}, 3);
        chk(!hben_o && !res_valid_o && !timeout_o, "R1 outputs low",
            {hben_o, res_valid_o, timeout_o}, 0);
    endtask

    task automatic t_mode_latch;
        bit v, e, rel;
        logic [15:0] dat;
        int n0;
        slow = 1'b0; byt = 1'b0; hb_seen = 1'b0;
        n0 = n_start;
        pulse_req();
        repeat (3) @(negedge clk);
        slow = 1'b1; byt = 1'b1;
        get_result(v, e, dat, rel);
        chk(v && (n_start - n0 == 1), "R12 sequence kept", n_start - n0, 1);
        chk(dat == {4'h0, sample(n_start - 1)}, "R12 data", dat, {4'h0, sample(n_start - 1)});
        chk(!hb_seen, "R12 no upper read", hb_seen, 0);
        slow = 1'b0; byt = 1'b0;
    endtask

    task automatic t_same_cycle;
        bit v, e, rel;
        logic [15:0] dat;
        int n0;
        slow = 1'b0; byt = 1'b0;
        pulse_req();
        for (int i = 0; i < 3000 && !res_valid_o; i++) @(negedge clk);
        req = 1'b1;
        n0 = n_start;
        @(negedge clk); req = 1'b0;
        get_result(v, e, dat, rel);
        chk(v, "R11 request in valid cycle served", v, 1);
        chk(n_start - n0 == 1, "R11 one more start", n_start - n0, 1);
        chk(dat == {4'h0, sample(n_start - 1)}, "R11 data", dat, {4'h0, sample(n_start - 1)});
    endtask

    task automatic t_merge;
        int nv;
        int n0;
        nv = 0;
        n0 = n_start;
        pulse_req();
        repeat (5) @(negedge clk);
        pulse_req();
        repeat (3) @(negedge clk);
        pulse_req();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (res_valid_o) nv++;
        end
        chk(nv == 2, "R11 merged requests", nv, 2);
        chk(n_start - n0 == 2, "R11 merged starts", n_start - n0, 2);
    endtask

    task automatic t_timeout;
        bit v, e, rel;
        logic [15:0] dat;
        int n0;
        dead = 1'b1; slow = 1'b1; byt = 1'b0;
        n0 = n_start;
        pulse_req();
        get_result(v, e, dat, rel);
        chk(e && !v, "R10 timeout flagged", e, 1);
        chk(rel, "R10 strobes released", rel, 1);
        @(negedge clk);
        chk(!timeout_o, "R10 timeout one cycle", timeout_o, 0);
        chk(n_start == n0, "R10 no conversion", n_start - n0, 0);
        dead = 1'b0;
        run_seq(1'b0, 1'b0, 1'b0, 2, "R10 R4 after timeout");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        run_seq(1'b1, 1'b0, 1'b0, 1, "R2 slow full");
        run_seq(1'b1, 1'b1, 1'b1, 1, "R3 R8 slow bytes");
        run_seq(1'b0, 1'b0, 1'b0, 2, "R4 unprimed full");
        run_seq(1'b0, 1'b0, 1'b0, 1, "R4 primed full");
        run_seq(1'b0, 1'b1, 1'b1, 1, "R5 R8 primed bytes");
        run_seq(1'b1, 1'b0, 1'b0, 1, "R2 slow full again");
        run_seq(1'b0, 1'b1, 1'b1, 2, "R5 unprimed bytes");
        t_mode_latch();
        t_same_cycle();
        t_merge();
        t_timeout();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule